// File: doc/BRIEF.md
# Merged Signed Multiply-Accumulate with Deferred-Carry Final Adder

This block computes a signed dot product, one operand pair per clock. Each pair is a 16-bit two's complement feature and a 16-bit two's complement weight. A stream begins with a pair marked start and ends with a pair marked last. Cycles with valid low inside a stream add nothing. When the stream has drained, the block presents the 43-bit two's complement total and raises done for one cycle. The 43 bits are the 32 product bits plus 11 bits of headroom.

Partial products are formed with a sign-correcting scheme, so the array never sees a negative row. The running total is fed back into the same carry-save compression as one more row. A single register stage captures the sum and carry vectors. After it, one final adder both completes the product and performs the accumulation. That adder is cut into short ripple sections. Only the carry between sections is registered and it is applied one cycle later, so intermediate totals are not meaningful. After the last pair, a fixed number of zero-input cycles lets every deferred carry settle. Only then is the total sampled to the output.

Top module: `dfc_mac`

## Requirements
- R1: While reset is high and in the cycle after it, done_o is 0 and result_o is all zeros.
- R2: At done, result_o equals the sum of feature × weight over every accepted pair of the stream. Both operands are read as 16-bit two's complement, and the result is 43-bit two's complement.
- R3: A valid pair with start high clears all earlier accumulation and becomes the first term. This also holds in the middle of an open stream, where the earlier terms are discarded.
- R4: done_o is high for exactly one cycle. It rises on the clock edge NSEC+1 edges after the edge that accepted the last pair (5 with the default NSEC = 4 sections).
- R5: result_o keeps its value in every cycle that is not a done cycle.
- R6: Inside an open stream, cycles with in_valid_i low add nothing, whatever the data inputs carry.
- R7: Some valid pairs are ignored and change neither done_o nor result_o. These are pairs arriving while no stream is open and start is low, and pairs arriving from the edge that accepted last up to the done edge.
- R8: Extreme operands are exact; for example, 2047 terms of (−32768)×(−32768) give 2047·2^30. A total beyond the 43-bit range wraps modulo 2^43.
- R9: A pair carrying both start and last forms a complete one-term stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operand pair present this cycle |
| in_start_i | input | 1 | Pair is the first of a stream |
| in_last_i | input | 1 | Pair is the last of a stream |
| feature_i | input | 16 | Signed feature operand |
| weight_i | input | 16 | Signed weight operand |
| result_o | output | 43 | Signed accumulated total, registered |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The assertions assume a stream protocol on the inputs: a stream is opened only by a valid pair carrying start, and it closes when its last pair is accepted. Anything offered during the drain window that follows counts as ignored, not as a protocol breach. The bench drives inputs only on falling edges and keeps reset high for several cycles before releasing it. Some stimulus deliberately strays from the protocol: stray valid pairs while idle, pairs with start during the drain, and a restart in mid-stream. None of this takes the inputs outside what the assertions accept, because the assertions judge such pairs by the same acceptance rule. The extreme streams keep their totals within 43 bits, except one stream that is meant to show the wrap.

// File: rtl/dfc_mac_pkg.sv
`timescale 1ns/1ps
package dfc_mac_pkg;

  // Controller phases of one dot-product stream
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } dfc_state_e;

endpackage

// File: rtl/dfc_pp_rows.sv
`timescale 1ns/1ps
// Signed partial-product rows using sign-bit complementing and a constant
// correction row, so every row is a plain non-negative bit vector.
module dfc_pp_rows #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 43
) (
  input  logic                             en_i,
  input  logic [IN_W-1:0]                  a_i,
  input  logic [IN_W-1:0]                  b_i,
  output logic [IN_W:0][ACC_W-1:0]         rows_o
);

  localparam logic [ACC_W-1:0] ONE_W = {{(ACC_W-1){1'b0}}, 1'b1};
  // 2^IN_W - 2^(2*IN_W-1), taken modulo 2^ACC_W
  localparam logic [ACC_W-1:0] CORR  = (ONE_W << IN_W) - (ONE_W << (2*IN_W-1));

  for (genvar gi = 0; gi < IN_W; gi++) begin : g_row
    logic [IN_W-1:0] bits;
    for (genvar gj = 0; gj < IN_W; gj++) begin : g_col
      if ((gi == IN_W-1) != (gj == IN_W-1)) begin : g_inv
        assign bits[gj] = en_i & ~(a_i[gi] & b_i[gj]);
      end else begin : g_pos
        assign bits[gj] = en_i & a_i[gi] & b_i[gj];
      end
    end
    assign rows_o[gi] = ACC_W'(bits) << gi;
  end

  assign rows_o[IN_W] = en_i ? CORR : '0;

endmodule

// File: rtl/dfc_csa_tree.sv
`timescale 1ns/1ps
// Carry-save compression of ROWS operands into one sum and one carry vector,
// built from full adders per column, one 3:2 level per extra row.
module dfc_csa_tree #(
  parameter int ACC_W = 43,
  parameter int ROWS  = 18
) (
  input  logic [ROWS-1:0][ACC_W-1:0] rows_i,
  output logic [ACC_W-1:0]           sum_o,
  output logic [ACC_W-1:0]           cry_o
);

  localparam int LEVELS = ROWS - 1;

  logic [LEVELS-1:0][ACC_W-1:0] ps;
  logic [LEVELS-1:0][ACC_W-1:0] pc;

  assign ps[0] = rows_i[0];
  assign pc[0] = rows_i[1];

  for (genvar k = 1; k < LEVELS; k++) begin : g_lvl
    logic [ACC_W-1:0] maj;
    assign ps[k]  = ps[k-1] ^ pc[k-1] ^ rows_i[k+1];
    assign maj    = (ps[k-1] & pc[k-1]) | (ps[k-1] & rows_i[k+1]) |
                    (pc[k-1] & rows_i[k+1]);
    assign pc[k]  = {maj[ACC_W-2:0], 1'b0};
  end

  assign sum_o = ps[LEVELS-1];
  assign cry_o = pc[LEVELS-1];

endmodule

// File: rtl/dfc_split_adder.sv
`timescale 1ns/1ps
// Final adder cut into NSEC ripple sections. Each section takes its carry-in
// from outside (the previous cycle's registered carry-out of the section below).
module dfc_split_adder #(
  parameter int ACC_W = 43,
  parameter int NSEC  = 4
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic [NSEC-2:0]  cin_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [NSEC-2:0]  cout_o
);

  localparam int SEC_W = (ACC_W + NSEC - 1) / NSEC;
  localparam int TOP_W = ACC_W - (NSEC - 1) * SEC_W;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    localparam int LO = k * SEC_W;
    logic ci;
    if (k == 0) begin : g_c0
      assign ci = 1'b0;
    end else begin : g_cn
      assign ci = cin_i[k-1];
    end
    if (k == NSEC-1) begin : g_top
      assign sum_o[LO +: TOP_W] = a_i[LO +: TOP_W] + b_i[LO +: TOP_W] +
                                  {{(TOP_W-1){1'b0}}, ci};
    end else begin : g_mid
      logic [SEC_W:0] t;
      assign t = {1'b0, a_i[LO +: SEC_W]} + {1'b0, b_i[LO +: SEC_W]} +
                 {{SEC_W{1'b0}}, ci};
      assign sum_o[LO +: SEC_W] = t[SEC_W-1:0];
      assign cout_o[k]          = t[SEC_W];
    end
  end

endmodule

// File: rtl/dfc_mac.sv
`timescale 1ns/1ps
module dfc_mac
  import dfc_mac_pkg::*;
#(
  parameter  int IN_W    = 16,
  parameter  int GUARD_W = 11,
  parameter  int NSEC    = 4,
  localparam int ACC_W   = 2 * IN_W + GUARD_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             in_valid_i,
  input  logic             in_start_i,
  input  logic             in_last_i,
  input  logic [IN_W-1:0]  feature_i,
  input  logic [IN_W-1:0]  weight_i,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o
);

  localparam int ROWS  = IN_W + 2;
  localparam int CNT_W = $clog2(NSEC + 1);

  dfc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] s_q, c_q;
  logic [NSEC-2:0]  cy_q;

  logic accept, clear;
  logic [IN_W:0][ACC_W-1:0] pp_rows;
  logic [ROWS-1:0][ACC_W-1:0] all_rows;
  logic [ACC_W-1:0] fb, tree_s, tree_c, add_sum;
  logic [NSEC-2:0]  add_cout;

  assign accept = in_valid_i && (state_q != ST_DRAIN) &&
                  (in_start_i || (state_q == ST_RUN));
  assign clear  = accept && in_start_i;

  dfc_pp_rows #(.IN_W(IN_W), .ACC_W(ACC_W)) u_pp (
    .en_i  (accept),
    .a_i   (feature_i),
    .b_i   (weight_i),
    .rows_o(pp_rows)
  );

  // Running total enters the compression as row 0
  assign fb       = clear ? '0 : add_sum;
  assign all_rows = {pp_rows, fb};

  dfc_csa_tree #(.ACC_W(ACC_W), .ROWS(ROWS)) u_tree (
    .rows_i(all_rows),
    .sum_o (tree_s),
    .cry_o (tree_c)
  );

  dfc_split_adder #(.ACC_W(ACC_W), .NSEC(NSEC)) u_add (
    .a_i   (s_q),
    .b_i   (c_q),
    .cin_i (cy_q),
    .sum_o (add_sum),
    .cout_o(add_cout)
  );

  // Datapath registers: tree output plus deferred section carries
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s_q  <= '0;
      c_q  <= '0;
      cy_q <= '0;
    end else begin
      s_q  <= tree_s;
      c_q  <= tree_c;
      cy_q <= clear ? '0 : add_cout;
    end
  end

  // Stream control and registered outputs
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_RUN: begin
          if (accept) begin
            if (in_last_i) begin
              state_q <= ST_DRAIN;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_DRAIN: begin
          if (cnt_q == CNT_W'(NSEC)) begin
            result_o <= add_sum;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dfc_mac_checker.sv
`timescale 1ns/1ps
module dfc_mac_checker #(
  parameter int NSEC  = 4,
  parameter int ACC_W = 43
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             in_valid_i,
  input logic             in_start_i,
  input logic             in_last_i,
  input logic [ACC_W-1:0] result_o,
  input logic             done_o
);

  localparam int WIN_W = $clog2(NSEC + 2) + 1;

  // Protocol view: stream open flag and drain-window position
  logic             open_q;
  logic [WIN_W-1:0] win_q;
  logic             take;

  assign take = in_valid_i && (win_q == '0) && (in_start_i || open_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      open_q <= 1'b0;
      win_q  <= '0;
    end else if (win_q != '0) begin
      win_q <= (win_q == WIN_W'(NSEC + 1)) ? '0 : win_q + 1'b1;
    end else if (take) begin
      open_q <= !in_last_i;
      if (in_last_i) win_q <= WIN_W'(1);
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!done_o && result_o == '0));

  // R4
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R4
  a_r4_done_on_time: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_q == WIN_W'(NSEC + 1)) |=> done_o);

  // R7
  a_r7_no_stray_done: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_q != WIN_W'(NSEC + 1)) |=> !done_o);

  // R5
  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> $stable(result_o));

endmodule

bind dfc_mac dfc_mac_checker #(.NSEC(NSEC), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/dfc_mac_tb.sv
`timescale 1ns/1ps
module dfc_mac_tb_top;

  localparam int IN_W  = 16;
  localparam int ACC_W = 43;
  localparam int NSEC  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             v, s, l;
  logic [IN_W-1:0]  f, w;
  logic [ACC_W-1:0] result;
  logic             done;

  dfc_mac #(.IN_W(IN_W), .GUARD_W(11), .NSEC(NSEC)) dut_i (
    .clk_i(clk), .rst_i(rst), .in_valid_i(v), .in_start_i(s), .in_last_i(l),
    .feature_i(f), .weight_i(w), .result_o(result), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R2";

  // Behavioural reference state
  bit               m_open;
  int               m_drain;
  longint           m_acc;
  logic [ACC_W-1:0] m_result;
  bit               m_done;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sx(input logic [ACC_W-1:0] x);
    return longint'($signed(x));
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_reset();
    m_open = 0; m_drain = 0; m_acc = 0; m_result = '0; m_done = 0;
  endtask

  task automatic model_edge(input bit iv, input bit is, input bit il,
                            input logic [IN_W-1:0] fi, input logic [IN_W-1:0] wi);
    m_done = 0;
    if (m_drain != 0) begin
      if (m_drain == NSEC + 1) begin
        m_done   = 1;
        m_result = m_acc[ACC_W-1:0];
        m_drain  = 0;
      end else begin
        m_drain++;
      end
    end else if (iv && (is || m_open)) begin
      if (is) m_acc = 0;
      m_acc += longint'($signed(fi)) * longint'($signed(wi));
      m_open = !il;
      if (il) m_drain = 1;
    end
  endtask

  task automatic compare_outputs();
    check(done == m_done, "R4", "done", longint'(done), longint'(m_done));
    if (m_done)
      check(result == m_result, cur_tag, "result at done", sx(result), sx(m_result));
    else
      check(result == m_result, "R5", "held result", sx(result), sx(m_result));
  endtask

  task automatic step(input bit iv, input bit is, input bit il,
                      input logic [IN_W-1:0] fi, input logic [IN_W-1:0] wi);
    @(negedge clk);
    compare_outputs();
    v = iv; s = is; l = il; f = fi; w = wi;
    @(posedge clk);
    model_edge(iv, is, il, fi, wi);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 16'($urandom()), 16'($urandom()));
  endtask

  // mode 0 random, 1 min*min, 2 min*max, 3 random with valid-low gaps
  task automatic stream(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [IN_W-1:0] a, b;
      case (mode)
        1:       begin a = 16'h8000; b = 16'h8000; end
        2:       begin a = 16'h8000; b = 16'h7FFF; end
        default: begin a = 16'($urandom()); b = 16'($urandom()); end
      endcase
      if (mode == 3 && (i % 3 == 1))
        step(1'b0, 1'b0, 1'b0, 16'($urandom()), 16'($urandom()));
      step(1'b1, i == 0, i == n - 1, a, b);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1; v = 0; s = 0; l = 0; f = '0; w = '0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    check(result == '0, "R1", "result in reset", sx(result), 0);
    rst = 1'b0;
    @(posedge clk);

    // R2: random streams of several lengths
    cur_tag = "R2";
    for (int k = 0; k < 6; k++) begin
      stream(3 + 7 * k, 0);
      idle(NSEC + 3);
    end

    // R9: single-pair streams
    cur_tag = "R9";
    step(1'b1, 1'b1, 1'b1, 16'h8000, 16'h8000); idle(NSEC + 3);
    step(1'b1, 1'b1, 1'b1, 16'd7, 16'hFFFD);    idle(NSEC + 3);

    // R6: gaps with junk data
    cur_tag = "R6";
    stream(20, 3); idle(NSEC + 3);

    // R7: stray pairs while idle (no start), then pairs during drain window
    cur_tag = "R7";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, i == 4, 16'h7FFF, 16'h7FFF);
    idle(NSEC + 3);
    step(1'b1, 1'b1, 1'b0, 16'd100, 16'd3);
    step(1'b1, 1'b0, 1'b1, 16'd5, 16'hFFFF);
    for (int i = 0; i < NSEC + 2; i++) step(1'b1, 1'b1, 1'b0, 16'h4000, 16'h4000);
    idle(NSEC + 3);

    // R3: restart in the middle of a stream
    cur_tag = "R3";
    stream(6, 0);
    idle(2);
    for (int i = 0; i < 8; i++) step(1'b1, i == 0 || i == 4, i == 7, 16'($urandom()), 16'($urandom()));
    idle(NSEC + 3);

    // R8: extreme operands, exact and wrapping
    cur_tag = "R8";
    stream(2047, 1); idle(NSEC + 3);
    stream(2047, 2); idle(NSEC + 3);
    stream(4096, 1); idle(NSEC + 3);

    // R2: back-to-back streams without idle gaps
    cur_tag = "R2";
    for (int k = 0; k < 4; k++) stream(9 + k, 0);
    idle(NSEC + 3);

    finish_run();
  end

endmodule